// File: doc/BRIEF.md
# Edge-Sensed External Interrupt Controller

This block gathers interrupt requests from one non-maskable pin and four maskable pins and offers a single request to a CPU. Every pin passes through a synchroniser. An edge detector compares successive synchronised samples. The non-maskable line reacts to a falling edge. Each maskable line reacts to the rising or the falling edge, chosen by its own polarity bit. A maskable pin latches a request flag only while its pin-function bit marks it as an interrupt input. Each flag stays set until software clears it through a write-one-to-clear port.

Pending requests are filtered and then ranked. Each maskable line has its own enable bit, and the CPU's global mask bit blocks every maskable line. The non-maskable request ignores both. The winner's vector index is latched and offered to the CPU, and the offer stays steady until the CPU pulses acknowledge. The controller then drives a one-cycle pulse that tells the CPU to set its global mask bit. Accepting the non-maskable request also clears its internal pending flag.

The controller is a three-state machine:
- `ST_IDLE` waits for a request to be pending.
- `ST_OFFER` drives the request and the latched vector.
- `ST_GRANT` drives the mask-set pulse for one cycle.

Its transitions are:
- idle-to-offer, when any filtered request is pending.
- offer-to-grant, on acknowledge.
- grant-to-idle, unconditionally.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge on `nmi_pin` makes the block offer vector 7 even while `gmask` is 1. A rising edge on `nmi_pin` requests nothing.
- R2: When the non-maskable request and an enabled, unmasked maskable request are pending together, vector 7 is offered first.
- R3: For line n, `edge_rise[n]`=1 selects the rising edge and 0 selects the falling edge. The edge of the other direction leaves `irq_flags[n]` at 0.
- R4: `irq_flags[n]` is set by a selected edge only while `pin_func_en[n]`=1.
- R5: A flag whose `irq_en[n]` is 0 stays set but produces no request.
- R6: While `gmask` is 1, no maskable flag produces a request.
- R7: Among filtered maskable requests, line 0 wins and line 3 loses. The offered vector is 8+n.
- R8: `int_req` and `int_vec` hold steady until `int_ack`. The cycle after acknowledge, `set_mask` is 1 for exactly one cycle and `int_req` is 0.
- R9: A flag stays set until a 1 is written to its bit of `flag_clr`. A selected edge in the same cycle as a clear leaves the flag set.
- R10: After reset, `int_req`, `set_mask` and `irq_flags` are all 0.
- R11: Acknowledging the vector-7 offer clears the non-maskable pending state, so it is not offered again without a new falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, falling-edge sensed |
| irq_pin | input | 4 | Maskable interrupt pins |
| edge_rise | input | 4 | Per-line polarity: 1 rising, 0 falling |
| pin_func_en | input | 4 | Per-line pin function: 1 = interrupt input |
| irq_en | input | 4 | Per-line interrupt enable |
| gmask | input | 1 | Global mask bit from the CPU |
| int_ack | input | 1 | Acknowledge pulse from the CPU |
| flag_clr | input | 4 | Write-one-to-clear strobe for the request flags |
| int_req | output | 1 | Interrupt request to the CPU |
| int_vec | output | 4 | Vector index of the offered request |
| set_mask | output | 1 | One-cycle pulse that sets the CPU's global mask |
| irq_flags | output | 4 | Maskable request flags |

## Verification
The bench sweeps every polarity and pin-function setting on every line, firing the unselected edge before the selected one. A polarity inversion, or a flag that ignores pin-function, shows up as a wrong flag.

It crosses all fifteen flag patterns with all sixteen enable patterns. A reversed priority order or a leaking enable gives a wrong vector or a spurious request.

Three more corner cases are targeted:
- A clear that lands on the same cycle as a new edge: a design where clear wins drops a real request.
- A non-maskable request arriving together with a maskable one: a design that never clears the non-maskable state after acknowledge re-offers vector 7 forever.
- Changing the enables while an offer is held: a vector that is not latched moves under the CPU.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_GRANT = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/irq_edge_det.sv
// Synchroniser followed by a single-direction edge detector.
// Edges are suppressed until the pipeline holds real pin samples.
module irq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel_rise,
    output logic hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [SYNC_STAGES:0]   warm_q;
    logic                   lvl;

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            warm_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= lvl;
            warm_q <= {warm_q[SYNC_STAGES-1:0], 1'b1};
        end
    end

    always_comb begin
        if (!warm_q[SYNC_STAGES])
            hit = 1'b0;
        else if (sel_rise)
            hit = lvl & ~prev_q;
        else
            hit = ~lvl & prev_q;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Sticky request flags; a set in the same cycle as a clear wins.
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_o <= '0;
        else
            flags_o <= set_i | (flags_o & ~clr_i);
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority selection: non-maskable first, then line 0 up to line N-1.
module irq_prio_enc #(
    parameter int N            = 4,
    parameter int VEC_W        = 4,
    parameter int NMI_VEC      = 7,
    parameter int IRQ_VEC_BASE = 8
) (
    input  logic             nmi_pend,
    input  logic [N-1:0]     irq_pend,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

    always_comb begin
        any_o = nmi_pend | (|irq_pend);
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (irq_pend[i])
                vec_o = VEC_W'(IRQ_VEC_BASE + i);
        end
        if (nmi_pend)
            vec_o = NMI_CODE;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_IRQ        = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int VEC_W        = 4,
    parameter int NMI_VEC      = 7,
    parameter int IRQ_VEC_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic [N_IRQ-1:0] irq_pin,
    input  logic [N_IRQ-1:0] edge_rise,
    input  logic [N_IRQ-1:0] pin_func_en,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gmask,
    input  logic             int_ack,
    input  logic [N_IRQ-1:0] flag_clr,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec,
    output logic             set_mask,
    output logic [N_IRQ-1:0] irq_flags
);
    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

    logic [N_IRQ-1:0] irq_hit;
    logic [N_IRQ-1:0] irq_set;
    logic [N_IRQ-1:0] irq_pend;
    logic             nmi_hit;
    logic [0:0]       nmi_flag;
    logic             nmi_clr;
    logic             pend_any;
    logic [VEC_W-1:0] pend_vec;
    logic [VEC_W-1:0] vec_q;

    ctrl_state_t state_q, state_d;

    // Edge detection per maskable line
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (irq_pin[g]),
            .sel_rise (edge_rise[g]),
            .hit      (irq_hit[g])
        );
    end

    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_nmi_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (nmi_pin),
        .sel_rise (1'b0),
        .hit      (nmi_hit)
    );

    assign irq_set = irq_hit & pin_func_en;

    irq_flag_bank #(.N(N_IRQ)) u_irq_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (irq_set),
        .clr_i   (flag_clr),
        .flags_o (irq_flags)
    );

    irq_flag_bank #(.N(1)) u_nmi_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (nmi_hit),
        .clr_i   (nmi_clr),
        .flags_o (nmi_flag)
    );

    assign irq_pend = irq_flags & irq_en & {N_IRQ{~gmask}};

    irq_prio_enc #(
        .N            (N_IRQ),
        .VEC_W        (VEC_W),
        .NMI_VEC      (NMI_VEC),
        .IRQ_VEC_BASE (IRQ_VEC_BASE)
    ) u_prio (
        .nmi_pend (nmi_flag[0]),
        .irq_pend (irq_pend),
        .any_o    (pend_any),
        .vec_o    (pend_vec)
    );

    // State register and latched vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pend_any)
                vec_q <= pend_vec;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pend_any) state_d = ST_OFFER;
            ST_OFFER: if (int_ack)  state_d = ST_GRANT;
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_req  = 1'b0;
        set_mask = 1'b0;
        nmi_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: begin
                int_req = 1'b1;
                nmi_clr = int_ack && (vec_q == NMI_CODE);
            end
            ST_GRANT: set_mask = 1'b1;
            default: ;
        endcase
    end

    assign int_vec = vec_q;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
    parameter int N_IRQ        = 4,
    parameter int VEC_W        = 4,
    parameter int NMI_VEC      = 7,
    parameter int IRQ_VEC_BASE = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gmask,
    input logic             int_ack,
    input logic [N_IRQ-1:0] flag_clr,
    input logic [N_IRQ-1:0] pin_func_en,
    input logic             int_req,
    input logic [VEC_W-1:0] int_vec,
    input logic             set_mask,
    input logic [N_IRQ-1:0] irq_flags
);
    localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);
    localparam logic [VEC_W-1:0] LO_CODE  = VEC_W'(IRQ_VEC_BASE);
    localparam logic [VEC_W-1:0] HI_CODE  = VEC_W'(IRQ_VEC_BASE + N_IRQ - 1);

    // R8
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> (int_req && $stable(int_vec)));

    // R8
    ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> (set_mask && !int_req));

    // R8
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask |=> !set_mask);

    // R7
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((int_vec == NMI_CODE) || (int_vec >= LO_CODE && int_vec <= HI_CODE)));

    // R6
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_req) && int_vec != NMI_CODE) |-> !$past(gmask));

    // R4
    func_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_flags & ~$past(irq_flags) & ~$past(pin_func_en)) == '0));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_flags & $past(irq_flags & ~flag_clr)) == $past(irq_flags & ~flag_clr)));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
    .N_IRQ        (N_IRQ),
    .VEC_W        (VEC_W),
    .NMI_VEC      (NMI_VEC),
    .IRQ_VEC_BASE (IRQ_VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gmask       (gmask),
    .int_ack     (int_ack),
    .flag_clr    (flag_clr),
    .pin_func_en (pin_func_en),
    .int_req     (int_req),
    .int_vec     (int_vec),
    .set_mask    (set_mask),
    .irq_flags   (irq_flags)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       nmi_pin;
    logic [3:0] irq_pin;
    logic [3:0] edge_rise;
    logic [3:0] pin_func_en;
    logic [3:0] irq_en;
    logic       gmask;
    logic       int_ack;
    logic [3:0] flag_clr;
    logic       int_req;
    logic [3:0] int_vec;
    logic       set_mask;
    logic [3:0] irq_flags;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ext_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_pin     (nmi_pin),
        .irq_pin     (irq_pin),
        .edge_rise   (edge_rise),
        .pin_func_en (pin_func_en),
        .irq_en      (irq_en),
        .gmask       (gmask),
        .int_ack     (int_ack),
        .flag_clr    (flag_clr),
        .int_req     (int_req),
        .int_vec     (int_vec),
        .set_mask    (set_mask),
        .irq_flags   (irq_flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        flag_clr = 4'hF;
        step(1);
        flag_clr = 4'h0;
    endtask

    // Acknowledge the offer; the CPU then applies mask_after to gmask.
    task automatic do_ack(input logic mask_after, input string tag);
        int_ack = 1'b1;
        step(1);
        int_ack = 1'b0;
        gmask   = mask_after;
        chk({tag, " set_mask after ack"}, set_mask, 1);
        chk({tag, " req dropped after ack"}, int_req, 0);
        step(1);
        chk({tag, " set_mask single pulse"}, set_mask, 0);
    endtask

    function automatic int exp_vec(input int m);
        for (int i = 0; i < 4; i++)
            if (m[i]) return 8 + i;
        return 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; nmi_pin = 1'b1; irq_pin = 4'h0; edge_rise = 4'h0;
        pin_func_en = 4'h0; irq_en = 4'h0; gmask = 1'b1; int_ack = 1'b0; flag_clr = 4'h0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        chk("R10 int_req", int_req, 0);
        chk("R10 set_mask", set_mask, 0);
        chk("R10 irq_flags", irq_flags, 0);
        step(6);

        // R3 / R4 sweep: every line, polarity and pin-function setting
        for (int n = 0; n < 4; n++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int fe = 0; fe < 2; fe++) begin
                    edge_rise[n] = pol[0];
                    pin_func_en  = fe[0] ? (4'h1 << n) : 4'h0;
                    irq_pin[n]   = pol[0];
                    step(6);
                    clear_all();
                    irq_pin[n] = ~pol[0];
                    step(6);
                    chk($sformatf("R3 opposite edge line%0d pol%0d", n, pol), irq_flags, 0);
                    irq_pin[n] = pol[0];
                    step(6);
                    chk($sformatf("R4 selected edge line%0d pol%0d fe%0d", n, pol, fe),
                        irq_flags, fe ? (1 << n) : 0);
                end
            end
            irq_pin[n] = 1'b0;
            step(6);
            clear_all();
        end

        // R9 flags persist until cleared
        edge_rise = 4'hF; pin_func_en = 4'hF; irq_en = 4'h0; gmask = 1'b1;
        irq_pin = 4'h4;
        step(6);
        irq_pin = 4'h0;
        step(20);
        chk("R9 flag persists", irq_flags, 4);
        flag_clr = 4'h4;
        step(1);
        flag_clr = 4'h0;
        chk("R9 w1c clears", irq_flags, 0);

        // R9 set wins over a coincident clear
        irq_pin = 4'h2;
        step(6);
        irq_pin = 4'h0;
        step(6);
        chk("R9 flag before race", irq_flags, 2);
        irq_pin = 4'h2;
        step(2);
        flag_clr = 4'h2;
        step(1);
        flag_clr = 4'h0;
        step(1);
        chk("R9 set wins over clear", irq_flags, 2);
        irq_pin = 4'h0;
        step(6);
        clear_all();

        // R5 / R6 / R7 sweep: all flag patterns against all enable patterns
        for (int p = 1; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                gmask  = 1'b1;
                irq_en = e[3:0];
                irq_pin = p[3:0];
                step(6);
                irq_pin = 4'h0;
                chk($sformatf("R5 flags p%0d e%0d", p, e), irq_flags, p);
                chk($sformatf("R6 masked p%0d e%0d", p, e), int_req, 0);
                gmask = 1'b0;
                step(3);
                chk($sformatf("R7 req p%0d e%0d", p, e), int_req, ((p & e) != 0) ? 1 : 0);
                if ((p & e) != 0) begin
                    chk($sformatf("R7 vec p%0d e%0d", p, e), int_vec, exp_vec(p & e));
                    do_ack(1'b1, "R8");
                end else begin
                    gmask = 1'b1;
                    chk($sformatf("R5 no grant p%0d e%0d", p, e), set_mask, 0);
                end
                step(4);
                clear_all();
            end
        end

        // R8 offer held while enables, mask and flags change
        irq_en = 4'hF; gmask = 1'b1;
        irq_pin = 4'h4;
        step(6);
        gmask = 1'b0;
        step(3);
        chk("R8 offer line2", int_req, 1);
        chk("R8 vec line2", int_vec, 10);
        irq_en = 4'h0; gmask = 1'b1; irq_pin = 4'h5;
        step(6);
        chk("R8 req held", int_req, 1);
        chk("R8 vec held", int_vec, 10);
        do_ack(1'b1, "R8");
        irq_pin = 4'h0;
        step(6);
        clear_all();

        // R1 NMI with the mask set
        irq_en = 4'hF; gmask = 1'b1;
        nmi_pin = 1'b0;
        step(6);
        chk("R1 nmi req under mask", int_req, 1);
        chk("R1 nmi vec", int_vec, 7);
        do_ack(1'b1, "R1");
        step(4);
        chk("R11 nmi not re-offered", int_req, 0);
        nmi_pin = 1'b1;
        step(6);
        chk("R1 rising nmi ignored", int_req, 0);

        // R2 NMI beats a simultaneous maskable request, then R11
        gmask = 1'b0;
        irq_pin = 4'h8;
        nmi_pin = 1'b0;
        step(6);
        chk("R2 nmi first", int_vec, 7);
        chk("R2 req", int_req, 1);
        do_ack(1'b0, "R2");
        step(3);
        chk("R11 next offer req", int_req, 1);
        chk("R11 next offer line3", int_vec, 11);
        do_ack(1'b1, "R11");
        irq_pin = 4'h0; nmi_pin = 1'b1;
        step(6);
        clear_all();
        step(2);
        chk("R11 idle at end", int_req, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule